// File: doc/BRIEF.md
# Processor Local Bus Cycle Sequencer

This block is the bus-side sequencer of a 32-bit processor interface. Two internal requesters share it: a data port, which asks for memory reads and writes, I/O reads and writes, interrupt acknowledges and halt or shutdown announcements, and a code-prefetch port, which asks only for instruction fetches. The sequencer picks one request and runs one external cycle for it. During that cycle it drives the word address, active-low byte enables and a three-bit status code, and pulses an active-low address strobe. It then waits for the active-low ready input and returns a one-cycle done pulse, with the captured read data, to the requester it served.

The sequencer runs on a double-rate clock, `clk2`. An internal phase bit divides that clock by two, and every bus state spans two `clk2` periods. The states are named S_IDLE (no cycle), S_T1 (strobe low, outputs freshly valid) and S_T2 (the device responds; this state repeats as a wait state). The transitions are IDLE->T1 (a request is granted at a state boundary), T1->T2 (always, at the next boundary), T2->T2 (ready high at the boundary), T2->T1 (ready low and the other requester is waiting) and T2->IDLE (ready low and nothing is waiting). Every state change happens on the `clk2` edge that closes the second phase. A requester holds its request until it sees its done pulse and drops it on the next `clk2` edge.

Top module: `lbus_cycle_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in S_IDLE: `ads_n` high, `ddone` and `fdone` low and `wdata_oe` low. A cycle that is in progress is abandoned and produces no done pulse.
- R2: When a request waits in S_IDLE, `ads_n` falls at the next bus-state boundary, at most two `clk2` periods after the request appears. It then stays low for exactly two `clk2` periods (state T1) and is high at all other times.
- R3: Each bus state lasts two `clk2` periods. `ready_n` is sampled only at the boundary that ends a T2 state, and its value during T1 is ignored. A cycle with no wait state gives the done pulse four `clk2` periods after `ads_n` falls.
- R4: If `ready_n` is high at the end of a T2 state, one more T2 state (two `clk2` periods) is added and `ready_n` is sampled again. There is no limit on the number of wait states, so w wait states delay the done pulse by 2*w `clk2` periods.
- R5: The status `{mio, dc, wr}` comes from the data operation code `dop` as follows: 0 gives 110 (memory read), 1 gives 111 (memory write), 2 gives 010 (I/O read), 3 gives 011 (I/O write), 4 gives 000 (interrupt acknowledge), and 5 and 6 both give 101. Every prefetch cycle drives 100.
- R6: `dop`=5 (halt) drives address 0 with only byte lane 2 enabled (`be_n`=1011). `dop`=6 (shutdown) drives address 0 with only lane 0 enabled (`be_n`=1110). For both, `daddr` and `dbe` are ignored.
- R7: Other data cycles drive `daddr` and `be_n` = ~`dbe`. Prefetch cycles drive `faddr` with all four lanes enabled (`be_n`=0000).
- R8: Address, byte enables and status stay unchanged from the first `clk2` period of T1 until the cycle ends.
- R9: `wdata_oe` is high, with `wdata` equal to `dwdata`, only for status 111 and 011. It is high from the start of T1 until the boundary at which ready is accepted.
- R10: On completion, exactly the served requester gets a done pulse one `clk2` period wide, in the period after the accepting boundary. `rdata` then holds the `bus_rdata` value sampled at that boundary.
- R11: If both requesters wait at the same boundary, the data port is served first.
- R12: At the boundary that ends a cycle, the request of the requester just served is not considered. If the other requester waits, its T1 begins at that same boundary. Otherwise the sequencer returns to S_IDLE.
- R13: Status 001 is never driven while `ads_n` is low. `dop`=7 runs as a memory read (status 110).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq | input | 1 | Data port request, held until `ddone` |
| dop | input | 3 | Data operation code (see R5) |
| daddr | input | 30 | Data word address |
| dbe | input | 4 | Data byte lanes, active high |
| dwdata | input | 32 | Data to write |
| freq | input | 1 | Prefetch request, held until `fdone` |
| faddr | input | 30 | Prefetch word address |
| ready_n | input | 1 | Cycle end from the device, active low |
| bus_rdata | input | 32 | Read data from the bus |
| addr | output | 30 | Bus word address |
| be_n | output | 4 | Bus byte enables, active low |
| mio | output | 1 | Status: memory (1) or I/O (0) |
| dc | output | 1 | Status: data (1) or control (0) |
| wr | output | 1 | Status: write (1) or read (0) |
| ads_n | output | 1 | Address strobe, active low |
| wdata | output | 32 | Write data to the bus |
| wdata_oe | output | 1 | Write data drive enable |
| ddone | output | 1 | Data cycle done pulse |
| fdone | output | 1 | Prefetch cycle done pulse |
| rdata | output | 32 | Read data captured at completion |

## Verification
The completion of one cycle and the start of the next fall on the same boundary. In that cycle the done pulse of the finished requester rises, and the strobe of the waiting requester falls. This is provoked by raising both requests together while the sequencer is idle. The bench then checks, in the sample right after the data cycle's accepting boundary, that `ddone` is high, `ads_n` is low and the status already reads 100 with the prefetch address. A second overlap is checked on every single cycle: the served request is still high at its own completion boundary, and `ads_n` must stay high there.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_T1   = 2'd1,
        S_T2   = 2'd2
    } bstate_e;

    typedef enum logic [2:0] {
        OP_MRD  = 3'd0,
        OP_MWR  = 3'd1,
        OP_IORD = 3'd2,
        OP_IOWR = 3'd3,
        OP_INTA = 3'd4,
        OP_HALT = 3'd5,
        OP_SHUT = 3'd6,
        OP_RSVD = 3'd7
    } dop_e;

    // status bit order: {mio, dc, wr}
    localparam logic [2:0] ST_FETCH = 3'b100;

    function automatic logic [2:0] op_status(input logic [2:0] op);
        logic [2:0] s;
        case (op)
            OP_MRD:  s = 3'b110;
            OP_MWR:  s = 3'b111;
            OP_IORD: s = 3'b010;
            OP_IOWR: s = 3'b011;
            OP_INTA: s = 3'b000;
            OP_HALT: s = 3'b101;
            OP_SHUT: s = 3'b101;
            default: s = 3'b110;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lbus_phase.sv
module lbus_phase (
    input  logic clk2,
    input  logic rst,
    output logic ph2
);
    // ph2 high marks the second half of a bus state; the edge that ends it
    // is the only edge at which the sequencer changes state.
    always_ff @(posedge clk2) begin
        if (rst) ph2 <= 1'b0;
        else     ph2 <= ~ph2;
    end
endmodule

// File: rtl/lbus_arb.sv
module lbus_arb (
    input  logic dreq,
    input  logic freq,
    input  logic mask_d,
    input  logic mask_f,
    output logic gnt_d,
    output logic gnt_f
);
    logic eff_d;
    logic eff_f;

    always_comb begin
        eff_d = dreq & ~mask_d;
        eff_f = freq & ~mask_f;
        gnt_d = eff_d;
        gnt_f = eff_f & ~eff_d;
    end
endmodule

// File: rtl/lbus_fmt.sv
module lbus_fmt
    import lbus_pkg::*;
#(
    parameter  int AW = 32,
    parameter  int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic          sel_f,
    input  logic [2:0]    op,
    input  logic [AW-1:2] d_addr,
    input  logic [NB-1:0] d_be,
    input  logic [AW-1:2] f_addr,
    output logic [2:0]    status,
    output logic [AW-1:2] addr,
    output logic [NB-1:0] be_n
);
    localparam int HALT_LANE = 2;
    localparam int SHUT_LANE = 0;

    logic [NB-1:0] lane_be_n;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            always_comb begin
                if (sel_f)
                    lane_be_n[g] = 1'b0;
                else if (op == OP_HALT)
                    lane_be_n[g] = (g != HALT_LANE);
                else if (op == OP_SHUT)
                    lane_be_n[g] = (g != SHUT_LANE);
                else
                    lane_be_n[g] = ~d_be[g];
            end
        end
    endgenerate

    always_comb begin
        be_n = lane_be_n;
        if (sel_f) begin
            status = ST_FETCH;
            addr   = f_addr;
        end else begin
            status = op_status(op);
            addr   = (op == OP_HALT || op == OP_SHUT) ? '0 : d_addr;
        end
    end
endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq
    import lbus_pkg::*;
#(
    parameter  int AW = 32,
    parameter  int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic          clk2,
    input  logic          rst,
    input  logic          dreq,
    input  logic [2:0]    dop,
    input  logic [AW-1:2] daddr,
    input  logic [NB-1:0] dbe,
    input  logic [DW-1:0] dwdata,
    input  logic          freq,
    input  logic [AW-1:2] faddr,
    input  logic          ready_n,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:2] addr,
    output logic [NB-1:0] be_n,
    output logic          mio,
    output logic          dc,
    output logic          wr,
    output logic          ads_n,
    output logic [DW-1:0] wdata,
    output logic          wdata_oe,
    output logic          ddone,
    output logic          fdone,
    output logic [DW-1:0] rdata
);
    bstate_e       state;
    bstate_e       nxt;
    logic          ph2;
    logic          finish;
    logic          owner_f;
    logic          mask_d;
    logic          mask_f;
    logic          gnt_d;
    logic          gnt_f;
    logic          start;
    logic [2:0]    fmt_status;
    logic [AW-1:2] fmt_addr;
    logic [NB-1:0] fmt_be_n;
    logic [2:0]    st_q;
    logic [AW-1:2] addr_q;
    logic [NB-1:0] be_n_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          ddone_q;
    logic          fdone_q;

    lbus_phase u_phase (
        .clk2 (clk2),
        .rst  (rst),
        .ph2  (ph2)
    );

    assign finish = (state == S_T2) && ph2 && !ready_n;
    assign mask_d = finish && !owner_f;
    assign mask_f = finish && owner_f;

    lbus_arb u_arb (
        .dreq   (dreq),
        .freq   (freq),
        .mask_d (mask_d),
        .mask_f (mask_f),
        .gnt_d  (gnt_d),
        .gnt_f  (gnt_f)
    );

    lbus_fmt #(.AW(AW), .DW(DW)) u_fmt (
        .sel_f  (gnt_f),
        .op     (dop),
        .d_addr (daddr),
        .d_be   (dbe),
        .f_addr (faddr),
        .status (fmt_status),
        .addr   (fmt_addr),
        .be_n   (fmt_be_n)
    );

    assign start = ph2 && (gnt_d || gnt_f) && ((state == S_IDLE) || finish);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (ph2 && (gnt_d || gnt_f)) nxt = S_T1;
            S_T1:   if (ph2) nxt = S_T2;
            S_T2:   if (finish) nxt = (gnt_d || gnt_f) ? S_T1 : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk2) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk2) begin
        if (rst) begin
            owner_f <= 1'b0;
            st_q    <= '0;
            addr_q  <= '0;
            be_n_q  <= '1;
            wdata_q <= '0;
            rdata_q <= '0;
            ddone_q <= 1'b0;
            fdone_q <= 1'b0;
        end else begin
            ddone_q <= finish && !owner_f;
            fdone_q <= finish && owner_f;
            if (finish) rdata_q <= bus_rdata;
            if (start) begin
                owner_f <= gnt_f;
                st_q    <= fmt_status;
                addr_q  <= fmt_addr;
                be_n_q  <= fmt_be_n;
                wdata_q <= dwdata;
            end
        end
    end

    assign ads_n    = (state != S_T1);
    assign {mio, dc, wr} = st_q;
    assign addr     = addr_q;
    assign be_n     = be_n_q;
    assign wdata    = wdata_q;
    assign wdata_oe = (state != S_IDLE) && st_q[1] && st_q[0];
    assign ddone    = ddone_q;
    assign fdone    = fdone_q;
    assign rdata    = rdata_q;

    // R2
    ads_two_chk: assert property (@(posedge clk2) disable iff (rst)
        $fell(ads_n) |=> !ads_n);
    // R2
    ads_end_chk: assert property (@(posedge clk2) disable iff (rst)
        (!ads_n && $past(!ads_n)) |=> ads_n);
    // R3
    t1_hold_chk: assert property (@(posedge clk2) disable iff (rst)
        (state == S_T1 && !ph2) |=> state == S_T1);
    // R4
    wait_chk: assert property (@(posedge clk2) disable iff (rst)
        (state == S_T2 && ph2 && ready_n) |=> state == S_T2);
    // R8
    stable_chk: assert property (@(posedge clk2) disable iff (rst)
        (state == S_T2) |-> ($stable(addr) && $stable(be_n) && $stable({mio, dc, wr})));
    // R10
    done_ready_chk: assert property (@(posedge clk2) disable iff (rst)
        (ddone || fdone) |-> $past(!ready_n));
    // R10
    done_one_chk: assert property (@(posedge clk2) disable iff (rst)
        $onehot0({ddone, fdone}));
    // R6
    special_chk: assert property (@(posedge clk2) disable iff (rst)
        (!ads_n && {mio, dc, wr} == 3'b101) |-> (addr == '0 && $countones(~be_n) == 1));
    // R11
    prio_chk: assert property (@(posedge clk2) disable iff (rst)
        (state == S_IDLE && ph2 && dreq) |=> (state == S_T1 && {mio, dc, wr} != ST_FETCH));
    // R13
    no001_chk: assert property (@(posedge clk2) disable iff (rst)
        !ads_n |-> ({mio, dc, wr} != 3'b001));
endmodule

// File: tb/sim_lbus_cycle_seq.sv
module sim_lbus_cycle_seq;
    logic        clk2 = 1'b0;
    logic        rst = 1'b1;
    logic        dreq = 1'b0;
    logic [2:0]  dop = 3'd0;
    logic [29:0] daddr = '0;
    logic [3:0]  dbe = '0;
    logic [31:0] dwdata = '0;
    logic        freq = 1'b0;
    logic [29:0] faddr = '0;
    logic        ready_n = 1'b1;
    logic [31:0] bus_rdata = '0;
    logic [29:0] addr;
    logic [3:0]  be_n;
    logic        mio, dc, wr, ads_n, wdata_oe, ddone, fdone;
    logic [31:0] wdata, rdata;

    int errs = 0;
    int chks = 0;
    int cyc  = 0;

    always #5 clk2 = ~clk2;

    lbus_cycle_seq u0 (
        .clk2(clk2), .rst(rst), .dreq(dreq), .dop(dop), .daddr(daddr), .dbe(dbe),
        .dwdata(dwdata), .freq(freq), .faddr(faddr), .ready_n(ready_n),
        .bus_rdata(bus_rdata), .addr(addr), .be_n(be_n), .mio(mio), .dc(dc),
        .wr(wr), .ads_n(ads_n), .wdata(wdata), .wdata_oe(wdata_oe),
        .ddone(ddone), .fdone(fdone), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk2) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            chks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    function automatic logic [2:0] exp_st(input logic isf, input logic [2:0] op);
        if (isf) return 3'b100;
        case (op)
            3'd0: return 3'b110;
            3'd1: return 3'b111;
            3'd2: return 3'b010;
            3'd3: return 3'b011;
            3'd4: return 3'b000;
            3'd5: return 3'b101;
            3'd6: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    task automatic run_one(input logic isf, input logic [2:0] op, input logic [29:0] a,
                           input logic [3:0] be, input logic [31:0] wd, input int w);
        logic [2:0]  es;
        logic [29:0] ea;
        logic [3:0]  ebn;
        logic        eoe;
        logic [31:0] rd;
        int          lat;
        es  = exp_st(isf, op);
        ea  = (!isf && (op == 3'd5 || op == 3'd6)) ? '0 : a;
        ebn = isf ? 4'b0000 : (op == 3'd5) ? 4'b1011 : (op == 3'd6) ? 4'b1110 : ~be;
        eoe = es[1] & es[0];
        rd  = {2'b01, a} ^ (32'h0f0f_0000 + 32'(w));
        bus_rdata = rd;
        if (isf) begin
            freq = 1'b1; faddr = a;
        end else begin
            dreq = 1'b1; dop = op; daddr = a; dbe = be; dwdata = wd;
        end
        lat = 0;
        do begin
            @(negedge clk2);
            lat++;
        end while (ads_n && lat < 4);
        chk(lat <= 2, "R2 strobe latency", 64'(lat), 64'd2);
        chk({mio, dc, wr} == es, "R5 R13 status", 64'({mio, dc, wr}), 64'(es));
        chk(addr == ea, "R6 R7 address", 64'(addr), 64'(ea));
        chk(be_n == ebn, "R6 R7 byte enables", 64'(be_n), 64'(ebn));
        chk(wdata_oe == eoe, "R9 write enable at T1", 64'(wdata_oe), 64'(eoe));
        if (eoe) chk(wdata == wd, "R9 write data", 64'(wdata), 64'(wd));
        ready_n = 1'b0;
        for (int s = 1; s <= 5 + 2 * w; s++) begin
            @(negedge clk2);
            if (s < 4 + 2 * w) begin
                chk(ads_n == (s >= 2), "R2 R3 strobe width", 64'(ads_n), 64'(s >= 2));
                chk(addr == ea && be_n == ebn && {mio, dc, wr} == es, "R8 stable outputs",
                    64'({addr, be_n, mio, dc, wr}), 64'({ea, ebn, es}));
                chk(!ddone && !fdone, "R3 R4 no early done", 64'({ddone, fdone}), 64'd0);
                chk(wdata_oe == eoe, "R9 enable held", 64'(wdata_oe), 64'(eoe));
            end
            if (s == 2) ready_n = 1'b1;
            if (s == 3 + 2 * w) ready_n = 1'b0;
            if (s == 4 + 2 * w) begin
                chk({ddone, fdone} == {!isf, isf}, "R4 R10 done timing and target",
                    64'({ddone, fdone}), 64'({!isf, isf}));
                chk(ads_n, "R12 served request not reconsidered", 64'(ads_n), 64'd1);
                chk(!wdata_oe, "R9 enable released", 64'(wdata_oe), 64'd0);
                if (!es[0] || !es[1]) chk(rdata == rd, "R10 read data", 64'(rdata), 64'(rd));
                dreq = 1'b0; freq = 1'b0; ready_n = 1'b1;
            end
            if (s == 5 + 2 * w)
                chk(!ddone && !fdone && ads_n, "R10 pulse width", 64'({ddone, fdone, ads_n}), 64'd1);
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk2);
        chk(ads_n && !ddone && !fdone && !wdata_oe, "R1 reset state",
            64'({ads_n, ddone, fdone, wdata_oe}), 64'b1000);
        rst = 1'b0;
        @(negedge clk2);

        for (int op = 0; op < 8; op++)
            for (int w = 0; w < 3; w++)
                run_one(1'b0, 3'(op), 30'h0123_4560 + 30'(op * 16 + w),
                        4'((4'h1 << (op % 4)) | (w == 1 ? 4'hc : 4'h0)),
                        32'hA5A5_0000 + 32'(op * 256 + w), w);
        for (int w = 0; w < 4; w++)
            run_one(1'b1, 3'd0, 30'h2000_0000 + 30'(w * 4), 4'h0, 32'h0, w);
        run_one(1'b0, 3'd1, 30'h3fff_ffff, 4'hf, 32'hdead_beef, 9);

        // R11 R12: both requests together, then the prefetch follows without an idle state
        dreq = 1'b1; dop = 3'd0; daddr = 30'h0aaa_aaa0; dbe = 4'hf;
        freq = 1'b1; faddr = 30'h1555_5550;
        bus_rdata = 32'h1234_5678;
        lat = 0;
        do begin @(negedge clk2); lat++; end while (ads_n && lat < 4);
        chk({mio, dc, wr} == 3'b110, "R11 data first", 64'({mio, dc, wr}), 64'b110);
        for (int s = 1; s <= 9; s++) begin
            @(negedge clk2);
            if (s == 4) begin
                chk(ddone && !fdone, "R12 data done", 64'({ddone, fdone}), 64'b10);
                chk(!ads_n && {mio, dc, wr} == 3'b100 && addr == 30'h1555_5550,
                    "R12 prefetch starts at same boundary", 64'({ads_n, mio, dc, wr}), 64'b0100);
                dreq = 1'b0; ready_n = 1'b1; bus_rdata = 32'h8765_4321;
            end
            if (s == 3 || s == 7) ready_n = 1'b0;
            if (s == 8) begin
                chk(fdone && !ddone && rdata == 32'h8765_4321, "R10 R12 prefetch done",
                    64'({fdone, ddone, rdata}), 64'({2'b10, 32'h8765_4321}));
                freq = 1'b0; ready_n = 1'b1;
            end
            if (s == 9) chk(ads_n && !fdone, "R12 back to idle", 64'({ads_n, fdone}), 64'b10);
        end

        // R1: reset in the middle of a write cycle
        dreq = 1'b1; dop = 3'd1; daddr = 30'h0000_0100; dbe = 4'h3;
        lat = 0;
        do begin @(negedge clk2); lat++; end while (ads_n && lat < 4);
        repeat (3) @(negedge clk2);
        rst = 1'b1;
        repeat (2) @(negedge clk2);
        dreq = 1'b0;
        chk(ads_n && !wdata_oe && !ddone, "R1 reset abandons cycle",
            64'({ads_n, wdata_oe, ddone}), 64'b100);
        rst = 1'b0; ready_n = 1'b0;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk2);
            chk(ads_n && !ddone && !fdone, "R1 no done after reset",
                64'({ads_n, ddone, fdone}), 64'b100);
        end
        ready_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule